// File: doc/BRIEF.md
# Trap and Exception Entry Sequencer

This block runs the stack traffic that takes a processor into a software trap or an arithmetic exception, and back out again. When a trap request is accepted, the block captures the current program counter and status word. It writes them as a three-word frame onto the supervisor stack, which grows downward. It then hands the core a new program counter, a status word with the supervisor bit forced on, and the lowered supervisor stack pointer, all in one cycle.

A return request reverses the process. The stack is picked by the supervisor bit of the status word the core presents at that moment. The block reads the three frame words back and returns the restored status word, the program counter and the raised stack pointer. If the restored status word has its supervisor bit clear, the core drops back to user mode.

All memory traffic uses one word-wide request/acknowledge port. Every access is held steady until it is acknowledged, so memory of any latency can be attached.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is high and in the cycle after it falls, mem_req, busy, pc_load, sr_load, ssp_load and usp_load are all 0.
- R2: A software trap (trap_kind 0) with number n in 0..15 ends by loading pc_out with 0x80 + 4*n.
- R3: Divide-by-zero (trap_kind 1) loads 0x14. A bounds violation (trap_kind 2) loads 0x18. An overflow trap (trap_kind 3) loads 0x1C when the V flag, status bit 1, is 1.
- R4: An overflow trap request with V = 0 has no effect. No memory access occurs, no load strobe fires and busy stays 0.
- R5: Entry writes three words on the supervisor stack with base ssp_in. The order is the PC low half at base-2, then the PC high half at base-4, then the status word at base-6. The sequence ends with ssp_load and sp_out = base-6.
- R6: The status word written to the stack is sr_in unchanged. On entry, sr_out is sr_in with the supervisor bit (bit 13) set.
- R7: On a return, the base is ssp_in when bit 13 of sr_in is 1 and usp_in otherwise. Reads go to base, base+2 and base+4, in that order. The result is sr_out = word at base and pc_out = {word at base+2, word at base+4}. sp_out = base+6, strobed on ssp_load or usp_load to match the stack used.
- R8: A restored status word whose bit 13 is 0 is delivered on sr_out unchanged, which returns the core to user mode.
- R9: An access keeps mem_req high and mem_addr, mem_we and mem_wdata stable until mem_ack is seen. The sequence advances only on an acknowledged access.
- R10: If a trap request and a return request arrive in the same idle cycle, the trap is taken and the return is dropped. Requests that arrive while busy is 1 are ignored.
- R11: Each sequence ends in one cycle in which pc_load, sr_load and exactly one stack pointer strobe are high together and mem_req is low. busy is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Trap request, sampled while idle |
| trap_kind | input | 2 | 0 software, 1 divide-by-zero, 2 bounds, 3 overflow |
| trap_num | input | 4 | Software trap number |
| rte_req | input | 1 | Return-from-exception request |
| pc_in | input | 32 | Current program counter |
| sr_in | input | 16 | Current status word |
| usp_in | input | 32 | User stack pointer |
| ssp_in | input | 32 | Supervisor stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes this cycle |
| pc_load | output | 1 | Load pc_out into the program counter |
| pc_out | output | 32 | New program counter |
| sr_load | output | 1 | Load sr_out into the status word |
| sr_out | output | 16 | New status word |
| ssp_load | output | 1 | Load sp_out into the supervisor stack pointer |
| usp_load | output | 1 | Load sp_out into the user stack pointer |
| sp_out | output | 32 | New stack pointer value |
| busy | output | 1 | A sequence is in progress |

## Verification
A trap request and a return request can collide in one idle cycle. The bench raises both together and expects a full entry frame, with no frame read. A return pulsed halfway through an entry must also leave no trace, because any stray access or load afterwards breaks the idle comparison. The second overlap is between a pending access and its acknowledge. A rotating wait of zero to two cycles on every access checks that the address and data hold across the stall and that the closing load strobes come only after the last acknowledge.

// File: rtl/tse_pkg.sv
package tse_pkg;

    localparam int AW         = 32;
    localparam int DW         = 16;
    localparam int PCW        = 2 * DW;
    localparam int NUM_W      = 4;
    localparam int S_BIT      = 13;
    localparam int V_BIT      = 1;
    localparam int WORD_BYTES = DW / 8;
    localparam int FRAME_WORDS = 3;

    localparam logic [AW-1:0] SOFT_BASE  = AW'(32'h80);
    localparam logic [AW-1:0] VEC_DIVZ   = AW'(32'h14);
    localparam logic [AW-1:0] VEC_BOUNDS = AW'(32'h18);
    localparam logic [AW-1:0] VEC_OVF    = AW'(32'h1C);

    typedef enum logic [1:0] {
        K_SOFT   = 2'd0,
        K_DIVZ   = 2'd1,
        K_BOUNDS = 2'd2,
        K_OVF    = 2'd3
    } trap_kind_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_PC_LO,
        ST_PUSH_PC_HI,
        ST_PUSH_SR,
        ST_LOAD_VEC,
        ST_POP_SR,
        ST_POP_PC_HI,
        ST_POP_PC_LO,
        ST_RET_LOAD
    } seq_state_t;

    typedef struct packed {
        logic [PCW-1:0] pc;
        logic [DW-1:0]  sr;
        logic [AW-1:0]  base;
    } frame_t;

    typedef struct packed {
        logic [DW-1:0] sr;
        logic [DW-1:0] pc_hi;
        logic [DW-1:0] pc_lo;
    } popped_t;

    function automatic logic trap_taken(trap_kind_t k, logic [DW-1:0] sr);
        return (k != K_OVF) || sr[V_BIT];
    endfunction

    function automatic logic is_push(seq_state_t s);
        return (s == ST_PUSH_PC_LO) || (s == ST_PUSH_PC_HI) || (s == ST_PUSH_SR);
    endfunction

    function automatic logic is_pop(seq_state_t s);
        return (s == ST_POP_SR) || (s == ST_POP_PC_HI) || (s == ST_POP_PC_LO);
    endfunction

endpackage

// File: rtl/tse_vector.sv
module tse_vector
    import tse_pkg::*;
(
    input  logic [1:0]       kind,
    input  logic [NUM_W-1:0] num,
    output logic [AW-1:0]    vec
);
    localparam int SCALE_SH = 2;

    always_comb begin
        unique case (trap_kind_t'(kind))
            K_SOFT:   vec = SOFT_BASE + (AW'(num) << SCALE_SH);
            K_DIVZ:   vec = VEC_DIVZ;
            K_BOUNDS: vec = VEC_BOUNDS;
            default:  vec = VEC_OVF;
        endcase
    end
endmodule

// File: rtl/tse_stack_addr.sv
module tse_stack_addr
    import tse_pkg::*;
(
    input  seq_state_t    state,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] sp_final
);
    localparam logic [AW-1:0] STEP  = AW'(WORD_BYTES);
    localparam logic [AW-1:0] FRAME = AW'(WORD_BYTES * FRAME_WORDS);

    always_comb begin
        unique case (state)
            ST_PUSH_PC_LO: addr = base - STEP;
            ST_PUSH_PC_HI: addr = base - (STEP << 1);
            ST_PUSH_SR:    addr = base - FRAME;
            ST_POP_SR:     addr = base;
            ST_POP_PC_HI:  addr = base + STEP;
            ST_POP_PC_LO:  addr = base + (STEP << 1);
            default:       addr = base;
        endcase
    end

    always_comb begin
        if (state == ST_RET_LOAD) sp_final = base + FRAME;
        else                      sp_final = base - FRAME;
    end
endmodule

// File: rtl/tse_ctrl.sv
module tse_ctrl
    import tse_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             trap_req,
    input  logic [1:0]       trap_kind,
    input  logic             rte_req,
    input  logic [PCW-1:0]   pc_in,
    input  logic [DW-1:0]    sr_in,
    input  logic [AW-1:0]    usp_in,
    input  logic [AW-1:0]    ssp_in,
    input  logic [AW-1:0]    vec_in,
    input  logic             mem_ack,
    input  logic [DW-1:0]    mem_rdata,
    output seq_state_t       state,
    output logic [AW-1:0]    base,
    output logic             mem_req,
    output logic             mem_we,
    output logic [DW-1:0]    mem_wdata,
    output logic             pc_load,
    output logic             sr_load,
    output logic             ssp_load,
    output logic             usp_load,
    output logic [PCW-1:0]   pc_out,
    output logic [DW-1:0]    sr_out
);
    localparam logic [DW-1:0] S_MASK = DW'(1) << S_BIT;

    frame_t          frm;
    popped_t         pop;
    logic [AW-1:0]   vec_q;
    logic            ret_sup;
    logic            step_ok;

    assign step_ok = mem_req && mem_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            frm     <= '0;
            pop     <= '0;
            vec_q   <= '0;
            ret_sup <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (trap_req) begin
                        if (trap_taken(trap_kind_t'(trap_kind), sr_in)) begin
                            frm.pc   <= pc_in;
                            frm.sr   <= sr_in;
                            frm.base <= ssp_in;
                            vec_q    <= vec_in;
                            state    <= ST_PUSH_PC_LO;
                        end
                    end else if (rte_req) begin
                        ret_sup  <= sr_in[S_BIT];
                        frm.base <= sr_in[S_BIT] ? ssp_in : usp_in;
                        state    <= ST_POP_SR;
                    end
                end
                ST_PUSH_PC_LO: if (step_ok) state <= ST_PUSH_PC_HI;
                ST_PUSH_PC_HI: if (step_ok) state <= ST_PUSH_SR;
                ST_PUSH_SR:    if (step_ok) state <= ST_LOAD_VEC;
                ST_LOAD_VEC:   state <= ST_IDLE;
                ST_POP_SR: if (step_ok) begin
                    pop.sr <= mem_rdata;
                    state  <= ST_POP_PC_HI;
                end
                ST_POP_PC_HI: if (step_ok) begin
                    pop.pc_hi <= mem_rdata;
                    state     <= ST_POP_PC_LO;
                end
                ST_POP_PC_LO: if (step_ok) begin
                    pop.pc_lo <= mem_rdata;
                    state     <= ST_RET_LOAD;
                end
                ST_RET_LOAD:   state <= ST_IDLE;
                default:       state <= ST_IDLE;
            endcase
        end
    end

    assign base = frm.base;

    always_comb begin
        mem_req = is_push(state) || is_pop(state);
        mem_we  = is_push(state);
        unique case (state)
            ST_PUSH_PC_LO: mem_wdata = frm.pc[DW-1:0];
            ST_PUSH_PC_HI: mem_wdata = frm.pc[PCW-1:DW];
            ST_PUSH_SR:    mem_wdata = frm.sr;
            default:       mem_wdata = '0;
        endcase
    end

    always_comb begin
        pc_load  = 1'b0;
        sr_load  = 1'b0;
        ssp_load = 1'b0;
        usp_load = 1'b0;
        pc_out   = '0;
        sr_out   = '0;
        if (state == ST_LOAD_VEC) begin
            pc_load  = 1'b1;
            sr_load  = 1'b1;
            ssp_load = 1'b1;
            pc_out   = PCW'(vec_q);
            sr_out   = frm.sr | S_MASK;
        end else if (state == ST_RET_LOAD) begin
            pc_load  = 1'b1;
            sr_load  = 1'b1;
            ssp_load = ret_sup;
            usp_load = !ret_sup;
            pc_out   = {pop.pc_hi, pop.pc_lo};
            sr_out   = pop.sr;
        end
    end

    // R9: a stalled access keeps the sequencer where it is
    p_stall_holds_state_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> $stable(state));

    // R10: a request raised mid-sequence never restarts it
    p_busy_ignores_req_r10: assert property (@(posedge clk) disable iff (rst)
        (is_push(state) && rte_req) |=> !is_pop(state));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import tse_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             trap_req,
    input  logic [1:0]       trap_kind,
    input  logic [NUM_W-1:0] trap_num,
    input  logic             rte_req,
    input  logic [PCW-1:0]   pc_in,
    input  logic [DW-1:0]    sr_in,
    input  logic [AW-1:0]    usp_in,
    input  logic [AW-1:0]    ssp_in,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_ack,
    output logic             pc_load,
    output logic [PCW-1:0]   pc_out,
    output logic             sr_load,
    output logic [DW-1:0]    sr_out,
    output logic             ssp_load,
    output logic             usp_load,
    output logic [AW-1:0]    sp_out,
    output logic             busy
);
    seq_state_t    state;
    logic [AW-1:0] base;
    logic [AW-1:0] vec;

    tse_vector u_vec (
        .kind (trap_kind),
        .num  (trap_num),
        .vec  (vec)
    );

    tse_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .trap_req  (trap_req),
        .trap_kind (trap_kind),
        .rte_req   (rte_req),
        .pc_in     (pc_in),
        .sr_in     (sr_in),
        .usp_in    (usp_in),
        .ssp_in    (ssp_in),
        .vec_in    (vec),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .state     (state),
        .base      (base),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .pc_load   (pc_load),
        .sr_load   (sr_load),
        .ssp_load  (ssp_load),
        .usp_load  (usp_load),
        .pc_out    (pc_out),
        .sr_out    (sr_out)
    );

    tse_stack_addr u_addr (
        .state    (state),
        .base     (base),
        .addr     (mem_addr),
        .sp_final (sp_out)
    );

    assign busy = (state != ST_IDLE);

    // R9: address, direction and data hold across a stall
    p_hold_access_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    // R11: loads close a sequence together, with no access in flight
    p_loads_together_r11: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> (sr_load && !mem_req && $onehot({ssp_load, usp_load})));

    // R11: idle follows the load cycle
    p_idle_after_load_r11: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> !busy);

    // R4: no traffic while idle
    p_quiet_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !pc_load && !ssp_load && !usp_load));

    // R6 / R2: an entry ends supervisor-side with a word-aligned low vector
    p_entry_vector_r6: assert property (@(posedge clk) disable iff (rst)
        (pc_load && $past(mem_we)) |-> (sr_out[S_BIT] && ssp_load
                                       && pc_out < PCW'(32'h100) && pc_out[1:0] == 2'b00));
endmodule

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;

    typedef struct {
        bit        we;
        bit [31:0] addr;
        bit [15:0] data;
        string     tag;
    } txn_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trap_req = 1'b0;
    logic [1:0]  trap_kind = 2'd0;
    logic [3:0]  trap_num = 4'd0;
    logic        rte_req = 1'b0;
    logic [31:0] pc_in = '0;
    logic [15:0] sr_in = '0;
    logic [31:0] usp_in = '0;
    logic [31:0] ssp_in = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        pc_load, sr_load, ssp_load, usp_load, busy;
    logic [31:0] pc_out, sp_out;
    logic [15:0] sr_out;

    exc_entry_seq u0 (
        .clk(clk), .rst(rst), .trap_req(trap_req), .trap_kind(trap_kind),
        .trap_num(trap_num), .rte_req(rte_req), .pc_in(pc_in), .sr_in(sr_in),
        .usp_in(usp_in), .ssp_in(ssp_in), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .pc_load(pc_load), .pc_out(pc_out), .sr_load(sr_load),
        .sr_out(sr_out), .ssp_load(ssp_load), .usp_load(usp_load),
        .sp_out(sp_out), .busy(busy)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int txn_count = 0;
    int hold_cnt = 0;
    bit finished = 0;

    logic [15:0] mem [bit [31:0]];
    txn_t        exp_q [$];
    bit          load_pending = 0;
    bit [31:0]   exp_pc, exp_sp;
    bit [15:0]   exp_sr;
    bit          exp_ssp_ld, exp_usp_ld;
    string       load_tag;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit [15:0] rd(bit [31:0] a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    // cycle-by-cycle reference comparison and memory responder
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (exp_q.size() > 0) begin
                chk({exp_q[0].tag, " R9 req"}, {31'd0, mem_req}, 32'd1);
                chk({exp_q[0].tag, " busy"}, {31'd0, busy}, 32'd1);
                chk({exp_q[0].tag, " addr"}, mem_addr, exp_q[0].addr);
                chk({exp_q[0].tag, " we"}, {31'd0, mem_we}, {31'd0, exp_q[0].we});
                if (exp_q[0].we) chk({exp_q[0].tag, " wdata"}, {16'd0, mem_wdata}, {16'd0, exp_q[0].data});
                chk("R11 no early load", {31'd0, pc_load}, 32'd0);
                if (hold_cnt == 0) begin
                    mem_ack = 1'b1;
                    if (exp_q[0].we) mem[exp_q[0].addr] = exp_q[0].data;
                    else mem_rdata = rd(exp_q[0].addr);
                    void'(exp_q.pop_front());
                    txn_count++;
                    hold_cnt = (txn_count * 7) % 3;
                end else begin
                    mem_ack = 1'b0;
                    hold_cnt--;
                end
            end else if (load_pending) begin
                mem_ack = 1'b0;
                chk("R11 pc_load", {31'd0, pc_load}, 32'd1);
                chk("R11 sr_load", {31'd0, sr_load}, 32'd1);
                chk("R11 no access at load", {31'd0, mem_req}, 32'd0);
                chk({load_tag, " pc_out"}, pc_out, exp_pc);
                chk({load_tag, " sr_out"}, {16'd0, sr_out}, {16'd0, exp_sr});
                chk({load_tag, " sp_out"}, sp_out, exp_sp);
                chk({load_tag, " ssp_load"}, {31'd0, ssp_load}, {31'd0, exp_ssp_ld});
                chk({load_tag, " usp_load"}, {31'd0, usp_load}, {31'd0, exp_usp_ld});
                load_pending = 0;
            end else begin
                mem_ack = 1'b0;
                chk("R4/R11 idle quiet", {28'd0, mem_req, pc_load, ssp_load | usp_load, busy}, 32'd0);
            end
        end
    end

    task automatic wait_idle();
        do @(negedge clk); while (exp_q.size() > 0 || load_pending || busy);
    endtask

    task automatic push_entry(bit [1:0] k, bit [3:0] n, bit [31:0] pc, bit [15:0] sr, bit [31:0] ssp);
        bit [31:0] vec;
        case (k)
            2'd0: vec = 32'h80 + 32'(n) * 4;   // R2
            2'd1: vec = 32'h14;                 // R3
            2'd2: vec = 32'h18;                 // R3
            default: vec = 32'h1C;              // R3
        endcase
        exp_q.push_back('{1'b1, ssp - 2, pc[15:0], "R5 pc_lo"});
        exp_q.push_back('{1'b1, ssp - 4, pc[31:16], "R5 pc_hi"});
        exp_q.push_back('{1'b1, ssp - 6, sr, "R6 sr push"});
        exp_pc = vec; exp_sr = sr | 16'h2000; exp_sp = ssp - 6;
        exp_ssp_ld = 1; exp_usp_ld = 0;
        load_tag = (k == 2'd0) ? "R2 entry" : "R3 entry";
        load_pending = 1;
    endtask

    task automatic do_trap(bit [1:0] k, bit [3:0] n, bit [31:0] pc, bit [15:0] sr,
                           bit [31:0] ssp, bit with_rte);
        wait_idle();
        trap_req = 1; trap_kind = k; trap_num = n; pc_in = pc; sr_in = sr;
        ssp_in = ssp; usp_in = 32'h0000_7000; rte_req = with_rte;   // R10 when with_rte
        @(posedge clk);
        #1;
        if (k != 2'd3 || sr[1]) push_entry(k, n, pc, sr, ssp);
        @(negedge clk);
        trap_req = 0; rte_req = 0;
    endtask

    task automatic do_rte(bit [15:0] sr, bit [31:0] usp, bit [31:0] ssp);
        bit [31:0] b;
        wait_idle();
        rte_req = 1; sr_in = sr; usp_in = usp; ssp_in = ssp;
        @(posedge clk);
        #1;
        b = sr[13] ? ssp : usp;   // R7
        exp_q.push_back('{1'b0, b, 16'h0, "R7 pop sr"});
        exp_q.push_back('{1'b0, b + 2, 16'h0, "R7 pop pc_hi"});
        exp_q.push_back('{1'b0, b + 4, 16'h0, "R7 pop pc_lo"});
        exp_pc = {rd(b + 2), rd(b + 4)}; exp_sr = rd(b); exp_sp = b + 6;
        exp_ssp_ld = sr[13]; exp_usp_ld = !sr[13];
        load_tag = "R7/R8 return";
        load_pending = 1;
        @(negedge clk);
        rte_req = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {26'd0, mem_req, busy, pc_load, sr_load, ssp_load, usp_load}, 32'd0);
        rst = 0;
        @(negedge clk);
        chk("R1 after reset", {26'd0, mem_req, busy, pc_load, sr_load, ssp_load, usp_load}, 32'd0);

        do_trap(2'd0, 4'd0,  32'h0031_F200, 16'h0004, 32'h0000_5000, 0);   // R2 n=0
        do_trap(2'd0, 4'd5,  32'hA5A5_1234, 16'h0000, 32'h0000_4FFA, 0);   // R2 n=5
        do_trap(2'd0, 4'd15, 32'hFFFF_0002, 16'h2000, 32'h0001_0000, 0);   // R2 n=15
        do_trap(2'd1, 4'd0,  32'h0000_0100, 16'h0008, 32'h0000_6000, 0);   // R3 divide
        do_trap(2'd2, 4'd9,  32'h0000_0200, 16'h0010, 32'h0000_6000, 0);   // R3 bounds
        do_trap(2'd3, 4'd0,  32'h0000_0300, 16'h0002, 32'h0000_6000, 0);   // R3 overflow V=1
        do_trap(2'd3, 4'd0,  32'h0000_0400, 16'h0000, 32'h0000_6000, 0);   // R4 V=0 no effect
        repeat (4) @(negedge clk);

        // R5/R7/R8: enter from user mode, then return through the same frame
        do_trap(2'd0, 4'd3, 32'h0012_3456, 16'h001F, 32'h0000_8000, 0);
        do_rte(16'h2700, 32'h0000_7000, 32'h0000_7FFA);

        // R7: return from the user stack with a prepared frame
        mem[32'h0000_3000] = 16'h0015;
        mem[32'h0000_3002] = 16'hBEEF;
        mem[32'h0000_3004] = 16'hCAFE;
        do_rte(16'h0000, 32'h0000_3000, 32'h0000_9000);

        // R10: simultaneous requests, trap wins
        do_trap(2'd1, 4'd0, 32'h0000_0500, 16'h2001, 32'h0000_A000, 1);
        // R10: a return pulsed during a busy entry is ignored
        do_trap(2'd2, 4'd0, 32'h0000_0600, 16'h0000, 32'h0000_B000, 0);
        @(negedge clk);
        rte_req = 1; sr_in = 16'h2000;
        @(negedge clk);
        rte_req = 0;
        wait_idle();
        repeat (4) @(negedge clk);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule